// File: doc/BRIEF.md
# Configuration access port

This block gives a local bus master a way to issue PCI configuration reads and writes through two registers. The master first loads a 32-bit address word that names a target (bus number, device, function and dword register index) and carries an enable flag. A later read or write of the data register then launches exactly one dword-aligned configuration cycle on a simple request/acknowledge interface toward the target side. The local bus access stalls until that cycle finishes.

Narrow writes are steered by the low two address bits of the data register window. They become byte enables and shifted data on the dword cycle. Reads always return the whole dword, and software extracts the byte or halfword it wants. If the enable flag is clear, data register accesses finish locally and no cycle is issued. If the target stays silent longer than a programmable limit, the cycle is abandoned, the read returns all ones and a sticky master-abort flag is raised.

Top module: `cfg_access_port`

## Requirements
- R1: After reset, `lb_ack`, `cfg_req` and `mabort` are 0, and the address register reads back as 0.
- R2: The address register is at local offset 0x28. A dword write to it stores all 32 bits, and a read returns them unchanged, including the reserved bits and bits 1:0.
- R3: With address bit 31 set, a data register access (offsets 0x2C to 0x2F) starts one cycle. In that cycle `cfg_bus` is address bits 23:16, `cfg_dev` is bits 15:11, `cfg_fn` is bits 10:8 and `cfg_dword` is bits 7:2. Address bits 1:0 do not reach the cycle.
- R4: A data register read issues `cfg_we`=0 with `cfg_be`=4'b1111. `lb_ack` pulses on the clock edge after the edge that samples `cfg_ack`, and `lb_rdata` then equals `cfg_rdata`.
- R5: A byte write (`lb_size`=0) at offset 0x2C+n drives `cfg_be` = 1<<n and `cfg_wdata` = `lb_wdata` shifted left by 8·n.
- R6: A halfword write (`lb_size`=1) at 0x2C+n drives `cfg_be` = 4'b0011<<n, truncated to 4 bits, with data shifted left by 8·n. A dword write (`lb_size`=2 or 3) drives `cfg_be`=4'b1111 with unshifted data, whatever n is.
- R7: With address bit 31 clear, a data register access issues no cycle. `lb_ack` pulses on the edge after the request. A read returns 32'hFFFFFFFF and a write is dropped.
- R8: If `cfg_ack` does not arrive, `cfg_req` stays high for `abort_limit`+1 cycles and then drops. The access completes with `lb_rdata`=32'hFFFFFFFF, and `mabort` is set and stays set until reset.
- R9: Only one cycle is outstanding at a time. `cfg_req` and its fields stay stable until the cycle is acknowledged or aborted, `cfg_req` is low in the cycle after the acknowledge, and `lb_ack` is a one-cycle pulse.
- R10: An access to any other offset completes on the edge after the request, reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_req | input | 1 | Local access request, held until `lb_ack` |
| lb_we | input | 1 | 1 = write, 0 = read |
| lb_addr | input | LB_AW | Local byte address |
| lb_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| lb_wdata | input | 32 | Write data, right-justified |
| lb_rdata | output | 32 | Read data, valid with `lb_ack` |
| lb_ack | output | 1 | One-cycle completion pulse |
| abort_limit | input | TMO_W | Cycles to wait for the target, minus one |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle direction |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dword | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data, lane aligned |
| cfg_ack | input | 1 | Target completion pulse |
| cfg_rdata | input | 32 | Target read data, valid with `cfg_ack` |
| mabort | output | 1 | Sticky master-abort flag |

## Verification
The properties assume the target pulses `cfg_ack` for a single cycle and only while `cfg_req` is high. They also assume the local master holds `lb_req` until it sees `lb_ack` and then drops it. The bench's target model raises `cfg_ack` at the falling edge only after it has seen the request, and lowers it one cycle later. In its timeout case it stays silent and never acknowledges. The bench's driver waits for each acknowledge before it releases the request and starts the next access, so the bench never offers a second outstanding request.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned EN_BIT = 31;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cfgp_state_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dword;
  } cfgp_tgt_t;
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word,
  output logic              enable,
  output cfgp_tgt_t         tgt
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (wr_en) word <= wr_data;
  end

  always_comb begin
    enable    = word[EN_BIT];
    tgt.bus   = word[23:16];
    tgt.dev   = word[15:11];
    tgt.fn    = word[10:8];
    tgt.dword = word[7:2];
  end
endmodule

// File: rtl/cfgp_lanes.sv
module cfgp_lanes
  import cfgp_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] data
);
  logic wide;
  logic is_half;

  assign wide    = size[1];
  assign is_half = (size == SZ_HALF);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic at_ofs;
    logic at_next;
    assign at_ofs  = ({1'b0, ofs} == (OFS_W + 1)'(i));
    assign at_next = (({1'b0, ofs} + 1'b1) == (OFS_W + 1)'(i));
    assign be[i]   = wide | at_ofs | (is_half & at_next);
  end

  assign data = wide ? wdata : (wdata << {ofs, 3'b000});
endmodule

// File: rtl/cfgp_watch.sv
module cfgp_watch #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter int unsigned      LB_AW    = 8,
  parameter int unsigned      TMO_W    = 8,
  parameter logic [LB_AW-1:0] ADDR_OFS = 'h28,
  parameter logic [LB_AW-1:0] DATA_OFS = 'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_req,
  input  logic              lb_we,
  input  logic [LB_AW-1:0]  lb_addr,
  input  logic [1:0]        lb_size,
  input  logic [WORD_W-1:0] lb_wdata,
  output logic [WORD_W-1:0] lb_rdata,
  output logic              lb_ack,
  input  logic [TMO_W-1:0]  abort_limit,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [5:0]        cfg_dword,
  output logic [LANES-1:0]  cfg_be,
  output logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [WORD_W-1:0] cfg_rdata,
  output logic              mabort
);
  localparam int unsigned IDX_W = LB_AW - OFS_W;

  cfgp_state_e       state;
  cfgp_tgt_t         tgt_q;
  logic [WORD_W-1:0] addr_word;
  logic              addr_en;
  cfgp_tgt_t         addr_tgt;
  logic [LANES-1:0]  lane_be;
  logic [WORD_W-1:0] lane_data;
  logic              tmo_hit;
  logic              take;
  logic              hit_addr;
  logic              hit_data;
  logic [IDX_W-1:0]  word_idx;

  assign word_idx = lb_addr[LB_AW-1:OFS_W];
  assign hit_addr = (word_idx == ADDR_OFS[LB_AW-1:OFS_W]);
  assign hit_data = (word_idx == DATA_OFS[LB_AW-1:OFS_W]);
  assign take     = (state == ST_IDLE) && lb_req && !lb_ack;

  cfgp_addr_reg u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take && hit_addr && lb_we),
    .wr_data (lb_wdata),
    .word    (addr_word),
    .enable  (addr_en),
    .tgt     (addr_tgt)
  );

  cfgp_lanes u_lanes (
    .size  (lb_size),
    .ofs   (lb_addr[OFS_W-1:0]),
    .wdata (lb_wdata),
    .be    (lane_be),
    .data  (lane_data)
  );

  cfgp_watch #(.TMO_W(TMO_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == ST_IDLE),
    .limit   (abort_limit),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lb_ack    <= 1'b0;
      lb_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      tgt_q     <= '0;
      mabort    <= 1'b0;
    end else begin
      lb_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            lb_ack   <= 1'b1;
            lb_rdata <= '0;
            if (hit_addr) begin
              if (!lb_we) lb_rdata <= addr_word;
            end else if (hit_data) begin
              if (addr_en) begin
                lb_ack    <= 1'b0;
                cfg_req   <= 1'b1;
                cfg_we    <= lb_we;
                cfg_be    <= lb_we ? lane_be : '1;
                cfg_wdata <= lb_we ? lane_data : '0;
                tgt_q     <= addr_tgt;
                state     <= ST_WAIT;
              end else if (!lb_we) begin
                lb_rdata <= '1;
              end
            end
          end
        end
        ST_WAIT: begin
          if (cfg_ack) begin
            cfg_req  <= 1'b0;
            lb_ack   <= 1'b1;
            lb_rdata <= cfg_we ? '0 : cfg_rdata;
            state    <= ST_IDLE;
          end else if (tmo_hit) begin
            cfg_req  <= 1'b0;
            lb_ack   <= 1'b1;
            lb_rdata <= '1;
            mabort   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cfg_bus   = tgt_q.bus;
  assign cfg_dev   = tgt_q.dev;
  assign cfg_fn    = tgt_q.fn;
  assign cfg_dword = tgt_q.dword;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
  input logic        clk,
  input logic        rst,
  input logic        lb_ack,
  input logic [31:0] lb_rdata,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic [7:0]  cfg_bus,
  input logic [4:0]  cfg_dev,
  input logic [2:0]  cfg_fn,
  input logic [5:0]  cfg_dword,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        cfg_ack,
  input logic        mabort
);
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    lb_ack |=> !lb_ack);

  a_r9_no_ack_while_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> !lb_ack);

  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req || mabort));

  a_r9_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && $past(cfg_req)) |->
      $stable({cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be, cfg_wdata}));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ack) |=> (!cfg_req && lb_ack));

  a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (cfg_be != 4'b0000));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    mabort |=> mabort);

  a_r8_abort_ones: assert property (@(posedge clk) disable iff (rst)
    $rose(mabort) |-> (lb_ack && (lb_rdata == 32'hFFFF_FFFF)));
endmodule

bind cfg_access_port cfgp_checker u_cfgp_checker (
  .clk       (clk),
  .rst       (rst),
  .lb_ack    (lb_ack),
  .lb_rdata  (lb_rdata),
  .cfg_req   (cfg_req),
  .cfg_we    (cfg_we),
  .cfg_bus   (cfg_bus),
  .cfg_dev   (cfg_dev),
  .cfg_fn    (cfg_fn),
  .cfg_dword (cfg_dword),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_ack   (cfg_ack),
  .mabort    (mabort)
);

// File: tb/test_cfg_access_port.sv
module test_cfg_access_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lb_req = 1'b0;
  logic        lb_we = 1'b0;
  logic [7:0]  lb_addr = '0;
  logic [1:0]  lb_size = '0;
  logic [31:0] lb_wdata = '0;
  logic [31:0] lb_rdata;
  logic        lb_ack;
  logic [7:0]  abort_limit = 8'd200;
  logic        cfg_req;
  logic        cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_dword;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        mabort;

  always #10 clk = ~clk;

  cfg_access_port i_cfg_access_port (
    .clk(clk), .rst(rst), .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr),
    .lb_size(lb_size), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
    .abort_limit(abort_limit), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_dword(cfg_dword),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
    .cfg_rdata(cfg_rdata), .mabort(mabort)
  );

  typedef struct packed { logic [31:0] tag; logic [31:0] rd; } rsp_t;
  typedef struct packed { logic [31:0] tag; logic [31:0] hdr; logic [31:0] wd; } cyc_t;

  rsp_t rsp_q[$];
  cyc_t cyc_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  bit   tgt_silent = 1'b0;
  int   tgt_delay = 2;
  int   tcnt = 0;
  int   hi_cnt = 0;
  logic req_prev = 1'b0;
  logic ack_prev = 1'b0;
  logic [31:0] snap;

  function automatic logic [31:0] tgt_word(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] w);
    return {2'b10, w, f, d, b, 8'h5A};
  endfunction

  function automatic logic [31:0] hdr_of(logic we, logic [7:0] b, logic [4:0] d,
                                         logic [2:0] f, logic [5:0] w, logic [3:0] be);
    return {5'b0, we, b, d, f, w, be};
  endfunction

  task automatic check(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cycle(input logic [31:0] tag, input logic [31:0] hdr, input logic [31:0] wd);
    cyc_t c;
    c.tag = tag; c.hdr = hdr; c.wd = wd;
    cyc_q.push_back(c);
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] exp_rd, input logic [31:0] tag);
    rsp_t r;
    r.tag = tag; r.rd = exp_rd;
    rsp_q.push_back(r);
    @(negedge clk);
    lb_we = we; lb_addr = a; lb_size = sz; lb_wdata = wd; lb_req = 1'b1;
    do @(negedge clk); while (!lb_ack);
    lb_req = 1'b0;
  endtask

  // target model and cycle monitor
  always @(negedge clk) begin
    if (rst) begin
      cfg_ack = 1'b0; tcnt = 0; req_prev = 1'b0;
    end else begin
      if (cfg_req && !req_prev) begin
        snap = hdr_of(cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be);
        hi_cnt = 0;
        if (cyc_q.size() == 0) begin
          check("R7", 32'h1, 32'h0);
        end else begin
          cyc_t c;
          c = cyc_q.pop_front();
          check(c.tag, snap, c.hdr);
          check(c.tag, cfg_wdata, c.wd);
        end
      end
      if (cfg_req) begin
        hi_cnt++;
        check("R9", hdr_of(cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be), snap);
      end
      req_prev = cfg_req;
      if (cfg_ack) begin
        cfg_ack = 1'b0; tcnt = 0;
      end else if (cfg_req && !tgt_silent) begin
        if (tcnt == tgt_delay) begin
          cfg_ack = 1'b1;
          cfg_rdata = tgt_word(cfg_bus, cfg_dev, cfg_fn, cfg_dword);
        end else tcnt++;
      end
    end
  end

  // local bus response monitor
  always @(negedge clk) begin
    if (rst) ack_prev = 1'b0;
    else begin
      if (lb_ack) begin
        check("R9", {31'b0, ack_prev}, 32'h0);
        if (rsp_q.size() == 0) check("R9", 32'h1, 32'h0);
        else begin
          rsp_t r;
          r = rsp_q.pop_front();
          check(r.tag, lb_rdata, r.rd);
        end
      end
      ack_prev = lb_ack;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: act=hung exp=complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a2, a3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check("R1", {29'b0, lb_ack, cfg_req, mabort}, 32'h0);
    access(1'b0, 8'h28, 2'd2, '0, 32'h0, "R1");

    // R2 address register readback
    access(1'b1, 8'h28, 2'd2, 32'h7F3A_5BC7, 32'h0, "R2");
    access(1'b0, 8'h28, 2'd2, '0, 32'h7F3A_5BC7, "R2");

    // R7 enable clear: no cycle
    access(1'b0, 8'h2C, 2'd2, '0, 32'hFFFF_FFFF, "R7");
    access(1'b1, 8'h2C, 2'd2, 32'hDEAD_BEEF, 32'h0, "R7");
    check("R7", {31'b0, cfg_req}, 32'h0);

    // R3 / R4 dword read
    a2 = 32'h8012_4B1F;
    access(1'b1, 8'h28, 2'd2, a2, 32'h0, "R3");
    expect_cycle("R3", hdr_of(1'b0, 8'h12, 5'd9, 3'd3, 6'd7, 4'hF), 32'h0);
    access(1'b0, 8'h2C, 2'd2, '0, tgt_word(8'h12, 5'd9, 3'd3, 6'd7), "R4");

    // R5 byte writes
    for (int n = 0; n < 4; n++) begin
      expect_cycle("R5", hdr_of(1'b1, 8'h12, 5'd9, 3'd3, 6'd7, 4'(4'b0001 << n)), 32'hAB << (8 * n));
      access(1'b1, 8'h2C + 8'(n), 2'd0, 32'h0000_00AB, 32'h0, "R5");
    end

    // R6 halfword and dword writes
    for (int n = 0; n < 4; n++) begin
      expect_cycle("R6", hdr_of(1'b1, 8'h12, 5'd9, 3'd3, 6'd7, 4'(4'b0011 << n)), 32'hBEEF << (8 * n));
      access(1'b1, 8'h2C + 8'(n), 2'd1, 32'h0000_BEEF, 32'h0, "R6");
    end
    expect_cycle("R6", hdr_of(1'b1, 8'h12, 5'd9, 3'd3, 6'd7, 4'hF), 32'h1234_5678);
    access(1'b1, 8'h2E, 2'd2, 32'h1234_5678, 32'h0, "R6");

    // R10 other offsets
    access(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF, 32'h0, "R10");
    access(1'b0, 8'h10, 2'd2, '0, 32'h0, "R10");
    access(1'b0, 8'h28, 2'd2, '0, a2, "R10");

    // R3 / R4 maximal fields, different target latencies
    a3 = 32'h80FF_FFFF;
    access(1'b1, 8'h28, 2'd2, a3, 32'h0, "R3");
    tgt_delay = 0;
    expect_cycle("R3", hdr_of(1'b0, 8'hFF, 5'd31, 3'd7, 6'd63, 4'hF), 32'h0);
    access(1'b0, 8'h2F, 2'd0, '0, tgt_word(8'hFF, 5'd31, 3'd7, 6'd63), "R4");
    tgt_delay = 7;
    expect_cycle("R3", hdr_of(1'b0, 8'hFF, 5'd31, 3'd7, 6'd63, 4'hF), 32'h0);
    access(1'b0, 8'h2C, 2'd2, '0, tgt_word(8'hFF, 5'd31, 3'd7, 6'd63), "R4");

    // R8 timeout
    abort_limit = 8'd5;
    tgt_silent = 1'b1;
    expect_cycle("R8", hdr_of(1'b0, 8'hFF, 5'd31, 3'd7, 6'd63, 4'hF), 32'h0);
    access(1'b0, 8'h2C, 2'd2, '0, 32'hFFFF_FFFF, "R8");
    check("R8", hi_cnt, 32'd6);
    check("R8", {31'b0, mabort}, 32'h1);
    tgt_silent = 1'b0;
    abort_limit = 8'd200;
    tgt_delay = 1;
    expect_cycle("R8", hdr_of(1'b0, 8'hFF, 5'd31, 3'd7, 6'd63, 4'hF), 32'h0);
    access(1'b0, 8'h2C, 2'd2, '0, tgt_word(8'hFF, 5'd31, 3'd7, 6'd63), "R8");
    check("R8", {31'b0, mabort}, 32'h1);

    // R1 reset clears the flag and the address register
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", {29'b0, lb_ack, cfg_req, mabort}, 32'h0);
    access(1'b0, 8'h28, 2'd2, '0, 32'h0, "R1");

    repeat (3) @(negedge clk);
    check("R9", rsp_q.size() + cyc_q.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule